// File: doc/BRIEF.md
# String-to-Port Output Engine

This block moves a string of data items from memory to a single I/O port. A command supplies the item size (byte, word or doubleword), a direction flag, a pointer-width mode (16-bit or 32-bit), a repeat enable, a starting source pointer, a 16-bit port address and a count. For each item the engine reads memory at the current pointer and writes the returned data to the port. It then moves the pointer forward or backward by the item size.

Without repeat, the engine makes one transfer. With repeat, it makes as many transfers as the loaded count and decrements the count after each one. When the operation ends, a one-cycle done pulse reports the final pointer and count. Memory reads and port writes each use a request line that stays high until the other side answers, so the engine works with any response latency.

Size codes on every size field: 0 = byte, 1 = word, 2 = doubleword. Code 3 is handled as a doubleword.

Top module: `strout_engine`

## Requirements
- R1: After a synchronous reset, `mem_req`, `io_req` and `done` are low.
- R2: Each transfer raises `mem_req` once, with `mem_addr` equal to the effective pointer and `mem_size` equal to the command size. `mem_req` and `mem_addr` hold steady until a cycle in which `mem_rvalid` is high. The effective pointer is the full pointer in 32-bit mode. In 16-bit mode it is the low 16 bits, zero-extended.
- R3: After a read response, `io_req` rises with `io_port` equal to the command port and `io_size` equal to the command size. `io_data` carries the read data with the unused upper bytes zeroed: only bits 7:0 for a byte, only bits 15:0 for a word. `io_req` and `io_data` hold until `io_ack`. `mem_req` and `io_req` are never high together.
- R4: After each acknowledged write, the pointer moves by 1, 2 or 4 for byte, word or doubleword. It increases when the direction flag is 0 and decreases when it is 1.
- R5: In 16-bit mode only the low 16 pointer bits change, and they wrap modulo 2^16; the upper 16 bits keep their loaded value. In 32-bit mode the pointer wraps modulo 2^32.
- R6: With repeat enabled and a nonzero count N, exactly N transfers take place and `fin_cnt` reads 0 at done.
- R7: With repeat enabled and a zero count, no memory read or port write is issued. `done` pulses in the cycle after the start is taken, with `fin_ptr` equal to the loaded pointer and `fin_cnt` equal to 0.
- R8: Without repeat, exactly one transfer takes place and `fin_cnt` equals the loaded count.
- R9: `done` is high for exactly one cycle per operation. While it is high, `fin_ptr` and `fin_cnt` show the final pointer and count.
- R10: A `start` pulse that arrives while an operation is in progress is ignored. The running operation finishes with its original command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept command (while idle) |
| cmd_size | input | 2 | Item size code |
| cmd_dir | input | 1 | 0 = step up, 1 = step down |
| cmd_wide | input | 1 | 1 = 32-bit pointer, 0 = 16-bit pointer |
| cmd_rep | input | 1 | Repeat under count |
| cmd_ptr | input | 32 | Initial source pointer |
| cmd_port | input | 16 | Destination port address |
| cmd_cnt | input | 32 | Repeat count |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Read address |
| mem_size | output | 2 | Read size code |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| io_req | output | 1 | Port write request |
| io_port | output | 16 | Port address |
| io_size | output | 2 | Write size code |
| io_data | output | 32 | Write data |
| io_ack | input | 1 | Port write acknowledge |
| done | output | 1 | Operation complete pulse |
| fin_ptr | output | 32 | Final pointer |
| fin_cnt | output | 32 | Final count |

## Verification
The bench sweeps every size, direction, pointer mode and repeat setting. It uses counts of zero, one and three, and starting pointers placed so the steps cross the 16-bit and 32-bit wrap points. A design that carries into the upper half in 16-bit mode, or that steps by the wrong amount, ends with a wrong final pointer or reads from wrong addresses. A zero count with repeat is checked for a spurious read, which would show as an extra transfer or a late done. Unmasked upper data bytes, or a count that changes without repeat, show up on the port data and on `fin_cnt`. A start pulse injected in the middle of an operation shows up if the design reloads, because the results then differ from the original command's.

// File: rtl/strout_pkg.sv
package strout_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } state_e;

  // number of bytes moved per item, code 3 treated as doubleword
  function automatic int unsigned item_bytes(size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/strout_step.sv
module strout_step
  import strout_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic [PTR_W-1:0] ptr,
  input  size_e            size,
  input  logic             dir,
  input  logic             wide,
  output logic [PTR_W-1:0] ptr_next
);
  localparam int HI_W = PTR_W - NARROW_W;

  logic [PTR_W-1:0]    step;
  logic [PTR_W-1:0]    full_next;
  logic [NARROW_W-1:0] low_next;

  always_comb begin
    step      = PTR_W'(item_bytes(size));
    full_next = dir ? (ptr - step) : (ptr + step);
    low_next  = dir ? (ptr[NARROW_W-1:0] - step[NARROW_W-1:0])
                    : (ptr[NARROW_W-1:0] + step[NARROW_W-1:0]);
  end

  generate
    if (HI_W > 0) begin : g_split
      assign ptr_next = wide ? full_next : {ptr[PTR_W-1:NARROW_W], low_next};
    end else begin : g_flat
      assign ptr_next = full_next;
    end
  endgenerate
endmodule

// File: rtl/strout_seq.sv
module strout_seq
  import strout_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cmd_rep,
  input  logic cmd_cnt_zero,
  input  logic rep_q,
  input  logic cnt_last,
  input  logic mem_rvalid,
  input  logic io_ack,
  output logic mem_req,
  output logic io_req,
  output logic done,
  output logic load,
  output logic capture,
  output logic advance
);
  state_e state_q;
  logic   last_item;

  always_comb begin
    load      = (state_q == ST_IDLE) && start;
    capture   = (state_q == ST_RD) && mem_rvalid;
    advance   = (state_q == ST_WR) && io_ack;
    last_item = !rep_q || cnt_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      mem_req <= 1'b0;
      io_req  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          if (cmd_rep && cmd_cnt_zero) begin
            done <= 1'b1;
          end else begin
            state_q <= ST_RD;
            mem_req <= 1'b1;
          end
        end
        ST_RD: if (mem_rvalid) begin
          mem_req <= 1'b0;
          io_req  <= 1'b1;
          state_q <= ST_WR;
        end
        ST_WR: if (io_ack) begin
          io_req <= 1'b0;
          if (last_item) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            mem_req <= 1'b1;
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strout_engine.sv
module strout_engine
  import strout_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int NARROW_W = 16,
  parameter int PORT_W   = 16,
  parameter int CNT_W    = 32,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_dir,
  input  logic              cmd_wide,
  input  logic              cmd_rep,
  input  logic [PTR_W-1:0]  cmd_ptr,
  input  logic [PORT_W-1:0] cmd_port,
  input  logic [CNT_W-1:0]  cmd_cnt,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [1:0]        mem_size,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              io_req,
  output logic [PORT_W-1:0] io_port,
  output logic [1:0]        io_size,
  output logic [DATA_W-1:0] io_data,
  input  logic              io_ack,
  output logic              done,
  output logic [PTR_W-1:0]  fin_ptr,
  output logic [CNT_W-1:0]  fin_cnt
);
  localparam int LANES = DATA_W / 8;
  localparam int HI_W  = PTR_W - NARROW_W;

  size_e              size_q;
  logic               dir_q, wide_q, rep_q;
  logic [PTR_W-1:0]   ptr_q, ptr_nxt;
  logic [PORT_W-1:0]  port_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  data_q, data_masked;
  logic               load, capture, advance;
  logic [LANES-1:0]   lane_en;

  strout_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cmd_rep      (cmd_rep),
    .cmd_cnt_zero (cmd_cnt == '0),
    .rep_q        (rep_q),
    .cnt_last     (cnt_q == CNT_W'(1)),
    .mem_rvalid   (mem_rvalid),
    .io_ack       (io_ack),
    .mem_req      (mem_req),
    .io_req       (io_req),
    .done         (done),
    .load         (load),
    .capture      (capture),
    .advance      (advance)
  );

  strout_step #(.PTR_W(PTR_W), .NARROW_W(NARROW_W)) u_step (
    .ptr      (ptr_q),
    .size     (size_q),
    .dir      (dir_q),
    .wide     (wide_q),
    .ptr_next (ptr_nxt)
  );

  // per-lane enables select only the bytes the item size covers
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_en[i] = (i < item_bytes(size_q));
      assign data_masked[8*i +: 8] = lane_en[i] ? mem_rdata[8*i +: 8] : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= SZ_BYTE;
      dir_q  <= 1'b0;
      wide_q <= 1'b0;
      rep_q  <= 1'b0;
      ptr_q  <= '0;
      port_q <= '0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      if (load) begin
        size_q <= size_e'(cmd_size);
        dir_q  <= cmd_dir;
        wide_q <= cmd_wide;
        rep_q  <= cmd_rep;
        ptr_q  <= cmd_ptr;
        port_q <= cmd_port;
        cnt_q  <= cmd_cnt;
      end
      if (capture) data_q <= data_masked;
      if (advance) begin
        ptr_q <= ptr_nxt;
        if (rep_q) cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  generate
    if (HI_W > 0) begin : g_addr_split
      assign mem_addr = wide_q ? ptr_q : {{HI_W{1'b0}}, ptr_q[NARROW_W-1:0]};
    end else begin : g_addr_flat
      assign mem_addr = ptr_q;
    end
  endgenerate

  assign mem_size = size_q;
  assign io_size  = size_q;
  assign io_port  = port_q;
  assign io_data  = data_q;
  assign fin_ptr  = ptr_q;
  assign fin_cnt  = cnt_q;
endmodule

// File: rtl/strout_engine_chk.sv
module strout_engine_chk #(
  parameter int PTR_W  = 32,
  parameter int PORT_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic [PTR_W-1:0]  mem_addr,
  input logic              mem_rvalid,
  input logic              io_req,
  input logic [PORT_W-1:0] io_port,
  input logic [DATA_W-1:0] io_data,
  input logic              io_ack,
  input logic              done
);
  p_rst_quiet_r1: assert property (@(posedge clk)
    rst |=> (!mem_req && !io_req && !done));

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (io_req && !io_ack) |=> (io_req && $stable(io_data) && $stable(io_port)));

  p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid) |=> (io_req && !mem_req));

  p_one_side_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && io_req));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind strout_engine strout_engine_chk #(
  .PTR_W(PTR_W), .PORT_W(PORT_W), .DATA_W(DATA_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid),
  .io_req     (io_req),
  .io_port    (io_port),
  .io_data    (io_data),
  .io_ack     (io_ack),
  .done       (done)
);

// File: tb/test_strout_engine.sv
module test_strout_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cmd_size = '0;
  logic        cmd_dir = 1'b0, cmd_wide = 1'b0, cmd_rep = 1'b0;
  logic [31:0] cmd_ptr = '0, cmd_cnt = '0;
  logic [15:0] cmd_port = '0;
  logic        mem_req, io_req, done;
  logic [31:0] mem_addr, io_data, fin_ptr, fin_cnt;
  logic [1:0]  mem_size, io_size;
  logic [15:0] io_port;
  logic        mem_rvalid = 1'b0, io_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_run = 0, n_fail = 0, cycles = 0;
  int mem_lat = 0, io_lat = 0, mem_w = 0, io_w = 0;
  int n_xfer = 0, n_reads = 0;
  logic [31:0] exp_ptr = '0;
  logic [1:0]  cur_size = '0;
  logic        cur_dir = 1'b0, cur_wide = 1'b0;
  logic [15:0] cur_port = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strout_engine i_strout_engine (
    .clk(clk), .rst(rst), .start(start), .cmd_size(cmd_size), .cmd_dir(cmd_dir),
    .cmd_wide(cmd_wide), .cmd_rep(cmd_rep), .cmd_ptr(cmd_ptr), .cmd_port(cmd_port),
    .cmd_cnt(cmd_cnt), .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .io_req(io_req), .io_port(io_port),
    .io_size(io_size), .io_data(io_data), .io_ack(io_ack), .done(done),
    .fin_ptr(fin_ptr), .fin_cnt(fin_cnt)
  );

  function automatic logic [31:0] pat(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] eff(logic [31:0] p, logic w);
    return w ? p : {16'h0000, p[15:0]};
  endfunction

  function automatic logic [31:0] msk(logic [1:0] s);
    return (s == 2'd0) ? 32'h0000_00FF : (s == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] p, logic [1:0] s, logic d, logic w);
    logic [31:0] st;
    logic [15:0] lo;
    st = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
    if (w) return d ? p - st : p + st;
    lo = d ? p[15:0] - st[15:0] : p[15:0] + st[15:0];
    return {p[31:16], lo};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory and port responders with programmable latency
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0; io_ack <= 1'b0; mem_w <= 0; io_w <= 0;
    end else begin
      if (mem_rvalid) mem_rvalid <= 1'b0;
      else if (mem_req) begin
        if (mem_w >= mem_lat) begin
          mem_rvalid <= 1'b1; mem_rdata <= pat(mem_addr); mem_w <= 0;
        end else mem_w <= mem_w + 1;
      end
      if (io_ack) io_ack <= 1'b0;
      else if (io_req) begin
        if (io_w >= io_lat) begin io_ack <= 1'b1; io_w <= 0; end
        else io_w <= io_w + 1;
      end
    end
  end

  // transfer monitor: compares each accepted read and write with the model
  always @(negedge clk) begin
    cycles++;
    if (!rst && mem_req && mem_rvalid) begin
      n_reads++;
      chk(mem_addr == eff(exp_ptr, cur_wide), "R2 addr", mem_addr, eff(exp_ptr, cur_wide));
      chk(mem_size == cur_size, "R2 size", 32'(mem_size), 32'(cur_size));
    end
    if (!rst && io_req && io_ack) begin
      chk(io_port == cur_port, "R3 port", 32'(io_port), 32'(cur_port));
      chk(io_size == cur_size, "R3 size", 32'(io_size), 32'(cur_size));
      chk(io_data == (pat(eff(exp_ptr, cur_wide)) & msk(cur_size)), "R3 data",
          io_data, pat(eff(exp_ptr, cur_wide)) & msk(cur_size));
      exp_ptr = nxt(exp_ptr, cur_size, cur_dir, cur_wide);
      n_xfer++;
    end
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic run_op(logic [1:0] s, logic d, logic w, logic r, logic [31:0] p,
                        logic [31:0] c, bit intrude);
    int waited;
    int exp_n;
    logic [31:0] p0;
    @(negedge clk);
    cmd_size = s; cmd_dir = d; cmd_wide = w; cmd_rep = r; cmd_ptr = p; cmd_cnt = c;
    cmd_port = p[31:16] ^ 16'hC3A5;
    cur_size = s; cur_dir = d; cur_wide = w; cur_port = cmd_port;
    exp_ptr = p; p0 = p; n_xfer = 0; n_reads = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done && waited < 300) begin
      if (intrude && waited == 2) begin
        // R10: a second command while busy must change nothing
        cmd_size = ~s; cmd_dir = ~d; cmd_wide = ~w; cmd_ptr = ~p; cmd_cnt = 32'd9;
        cmd_port = ~cmd_port; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    exp_n = r ? int'(c) : 1;
    chk(done == 1'b1, "R9 done seen", 32'(done), 32'd1);
    if (r && c == 0) begin
      chk(waited == 1, "R7 done latency", 32'(waited), 32'd1);
      chk(n_reads == 0, "R7 no read", 32'(n_reads), 32'd0);
    end
    chk(n_xfer == exp_n, r ? "R6 transfer count" : "R8 single transfer",
        32'(n_xfer), 32'(exp_n));
    chk(fin_ptr == exp_ptr, intrude ? "R10 final pointer" : "R4 final pointer",
        fin_ptr, exp_ptr);
    if (!w) chk(fin_ptr[31:16] == p0[31:16], "R5 upper kept",
                32'(fin_ptr[31:16]), 32'(p0[31:16]));
    chk(fin_cnt == (r ? 32'd0 : c), r ? "R6 final count" : "R8 count kept",
        fin_cnt, r ? 32'd0 : c);
    @(negedge clk);
    chk(done == 1'b0, "R9 done width", 32'(done), 32'd0);
  endtask

  initial begin
    logic [31:0] ptrs [3];
    logic [31:0] cnts [3];
    int k;
    ptrs[0] = 32'h1234_FFFE; ptrs[1] = 32'h0000_0001; ptrs[2] = 32'hFFFF_FFFD;
    cnts[0] = 32'd0; cnts[1] = 32'd1; cnts[2] = 32'd3;
    repeat (3) @(negedge clk);
    chk(!mem_req && !io_req && !done, "R1 reset quiet",
        {29'd0, mem_req, io_req, done}, 32'd0);
    rst = 1'b0;
    k = 0;
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++)
          for (int r = 0; r < 2; r++)
            for (int pi = 0; pi < 3; pi++)
              for (int ci = 0; ci < 3; ci++) begin
                mem_lat = k % 3; io_lat = (k / 3) % 3; k++;
                run_op(2'(s), 1'(d), 1'(w), 1'(r), ptrs[pi], cnts[ci], 1'b0);
              end
    mem_lat = 2; io_lat = 1;
    run_op(2'd1, 1'b1, 1'b0, 1'b1, 32'hABCD_0002, 32'd3, 1'b1);
    run_op(2'd3, 1'b0, 1'b1, 1'b1, 32'hFFFF_FFFC, 32'd2, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule